// File: doc/BRIEF.md
# Link-Aggregation Aware Egress Mask Resolver

This block gives the egress port mask for a unicast frame in a small switch that bundles physical ports into link aggregation groups. Three port-group tables are read with one lookup. The forwarding table is indexed by the logical destination. The spreading table is indexed by a 4-bit aggregation code that an upstream hash produces. The ingress filter table is indexed by the source port. The returned mask is the bitwise AND of the three selected entries, and it is registered one cycle after the lookup is accepted.

A group is identified by its lowest-numbered member port. Learned addresses point at that logical index. When a group is declared, every member's forwarding entry is given the full group mask, and that entry keeps every member even while the member's link is down. Inactive members are removed only through the spreading table.

A sequencer rebuilds the spreading table whenever group membership or link state changes. It spends one cycle on each of the 16 entries. While a rebuild is pending or running, lookups and direct table writes are held off. The hash function and address learning live outside this block.

Top module: `lagres_mask_resolver`

## Requirements
- R1: An accepted lookup returns forward[dst] AND spread[code] AND ingress[src], where each is the table entry selected by that index.
- R2: A destination or source index at or above NUM_PORTS (7 with defaults) returns an all-zero mask.
- R3: After reset, forward[i] holds only bit i, every spread entry holds all ports, ingress[i] holds every port except bit i, no group exists, and the block reaches the ready state.
- R4: A group write (cfg_sel=3, cfg_idx=g, cfg_data=m) sets forward[p]=m for every member p of m and starts a rebuild. The member set stays complete whatever the link state.
- R5: A group write whose cfg_idx is at or above NUM_PORTS, or is not the lowest set bit of a non-zero cfg_data, is ignored. Direct writes use cfg_sel=0 for forward, 1 for spread and 2 for ingress.
- R6: A rebuild visits spread entries 0 to 15 in order, one per cycle. For each group, entry e has all member bits cleared, then gets the bit of the k-th active member in ascending port order, where k = e mod (active member count).
- R7: A group with no active member leaves none of its member bits set in any spread entry.
- R8: Writing cfg_data=0 to a group index dissolves the group: each former member p gets forward[p] = bit p only, and bit p is set in every spread entry.
- R9: While a rebuild is pending or running, lk_ready and cfg_ready are low, and lookups presented then produce no result.
- R10: Table writes presented while cfg_ready is low change no table.
- R11: res_valid is high exactly in the cycle after a lookup is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | NUM_PORTS | Per-port link state; any change triggers a rebuild |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Target: 0 forward, 1 spread, 2 ingress, 3 group |
| cfg_idx | input | log2(AGGR_CODES) | Entry index |
| cfg_data | input | NUM_PORTS | Entry value (port mask) |
| cfg_ready | output | 1 | Writes are accepted |
| lk_valid | input | 1 | Lookup request |
| lk_dst | input | log2(NUM_PORTS) | Logical destination index |
| lk_aggr | input | log2(AGGR_CODES) | Aggregation code |
| lk_src | input | log2(NUM_PORTS) | Ingress port |
| lk_ready | output | 1 | Lookup is accepted |
| res_valid | output | 1 | Result strobe |
| res_mask | output | NUM_PORTS | Resolved egress mask |

## Verification
Any wrong table bit shows up in the result mask of the very next lookup that selects that entry, which is one cycle after the lookup is accepted. Sweeping every destination, code and source after each reconfiguration therefore exposes each corrupted entry. A wrong member choice or ordering in the rebuild shows up as a member bit at the wrong code position. A missed clear leaves an inactive port in the mask. A missed stall shows up as a result taken from a half-rebuilt table, or as a direct write that lands during a rebuild.

// File: rtl/lagres_pkg.sv
package lagres_pkg;
    typedef enum logic [1:0] {
        SEL_FWD   = 2'd0,
        SEL_SPRD  = 2'd1,
        SEL_INGR  = 2'd2,
        SEL_GROUP = 2'd3
    } cfg_sel_e;
endpackage

// File: rtl/lagres_tables.sv
module lagres_tables
    import lagres_pkg::*;
#(
    parameter int P  = 7,
    parameter int E  = 16,
    parameter int AW = 4,
    parameter int PIW = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [1:0]          cfg_sel,
    input  logic [AW-1:0]       cfg_idx,
    input  logic [P-1:0]        cfg_data,
    input  logic                busy,
    input  logic                upd_en,
    input  logic [AW-1:0]       upd_idx,
    input  logic [P-1:0]        upd_clr,
    input  logic [P-1:0]        upd_set,
    output logic [P-1:0][P-1:0] fwd_tbl,
    output logic [E-1:0][P-1:0] sprd_tbl,
    output logic [P-1:0][P-1:0] ingr_tbl,
    output logic [P-1:0][P-1:0] grp_tbl,
    output logic                grp_trig
);
    typedef struct packed {
        logic [P-1:0][P-1:0] fwd;
        logic [E-1:0][P-1:0] sprd;
        logic [P-1:0][P-1:0] ingr;
        logic [P-1:0][P-1:0] grp;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic trig_d;

    function automatic int lowest_bit(input logic [P-1:0] m);
        int r;
        r = P;
        for (int i = P - 1; i >= 0; i--) begin
            if (m[i]) r = i;
        end
        return r;
    endfunction

    always_comb begin
        logic acc;
        logic idx_ok;
        logic [PIW-1:0] pidx;
        tbl_d  = tbl_q;
        trig_d = 1'b0;
        acc    = cfg_we && !busy;
        idx_ok = int'(cfg_idx) < P;
        pidx   = cfg_idx[PIW-1:0];
        if (upd_en) begin
            tbl_d.sprd[upd_idx] = (tbl_q.sprd[upd_idx] & ~upd_clr) | upd_set;
        end
        if (acc) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_FWD:  if (idx_ok) tbl_d.fwd[pidx] = cfg_data;
                SEL_SPRD: tbl_d.sprd[cfg_idx] = cfg_data;
                SEL_INGR: if (idx_ok) tbl_d.ingr[pidx] = cfg_data;
                default: begin
                    if (idx_ok && (cfg_data == '0 || lowest_bit(cfg_data) == int'(cfg_idx))) begin
                        for (int p = 0; p < P; p++) begin
                            if (tbl_q.grp[pidx][p]) begin
                                tbl_d.fwd[p]    = '0;
                                tbl_d.fwd[p][p] = 1'b1;
                                for (int e = 0; e < E; e++) tbl_d.sprd[e][p] = 1'b1;
                            end
                        end
                        for (int p = 0; p < P; p++) begin
                            if (cfg_data[p]) tbl_d.fwd[p] = cfg_data;
                        end
                        tbl_d.grp[pidx] = cfg_data;
                        trig_d = 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < P; i++) begin
                tbl_q.fwd[i]     <= '0;
                tbl_q.fwd[i][i]  <= 1'b1;
                tbl_q.ingr[i]    <= '1;
                tbl_q.ingr[i][i] <= 1'b0;
                tbl_q.grp[i]     <= '0;
            end
            for (int e = 0; e < E; e++) tbl_q.sprd[e] <= '1;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign fwd_tbl  = tbl_q.fwd;
    assign sprd_tbl = tbl_q.sprd;
    assign ingr_tbl = tbl_q.ingr;
    assign grp_tbl  = tbl_q.grp;
    assign grp_trig = trig_d;

    AST_CFG_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_we) |=> ($stable(tbl_q.fwd) && $stable(tbl_q.ingr) && $stable(tbl_q.grp))) // R10
        else $error("config write landed while busy");

    AST_GROUP_FWD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cfg_we && cfg_sel == 2'd3 && cfg_data != '0 && trig_d)
        |=> (tbl_q.fwd[lowest_bit($past(cfg_data))] == $past(cfg_data))) // R4
        else $error("group member forward entry not full mask");
endmodule

// File: rtl/lagres_rebuild.sv
module lagres_rebuild #(
    parameter int P  = 7,
    parameter int E  = 16,
    parameter int AW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trig,
    input  logic [P-1:0]        link_in,
    input  logic [P-1:0][P-1:0] grp_tbl,
    output logic                busy,
    output logic                upd_en,
    output logic [AW-1:0]       upd_idx,
    output logic [P-1:0]        upd_clr,
    output logic [P-1:0]        upd_set
);
    localparam logic [AW-1:0] LAST = AW'(E - 1);

    typedef struct packed {
        logic          run;
        logic          pend;
        logic [AW-1:0] cnt;
        logic [P-1:0]  seen;
        logic [P-1:0]  snap;
    } rb_t;

    rb_t rb_d, rb_q;

    always_comb begin
        logic chg;
        rb_d      = rb_q;
        chg       = link_in != rb_q.seen;
        rb_d.seen = link_in;
        rb_d.pend = rb_q.pend | trig | chg;
        if (!rb_q.run) begin
            if (rb_q.pend) begin
                rb_d.run  = 1'b1;
                rb_d.cnt  = '0;
                rb_d.snap = rb_q.seen;
                rb_d.pend = trig | chg;
            end
        end else if (rb_q.cnt == LAST) begin
            rb_d.run = 1'b0;
        end else begin
            rb_d.cnt = rb_q.cnt + 1'b1;
        end
    end

    always_comb begin
        upd_clr = '0;
        upd_set = '0;
        for (int g = 0; g < P; g++) begin
            logic [P-1:0] act;
            int n_act;
            int k;
            int c;
            upd_clr = upd_clr | grp_tbl[g];
            act     = grp_tbl[g] & rb_q.snap;
            n_act   = $countones(act);
            k       = 0;
            c       = 0;
            if (n_act != 0) begin
                k = int'(rb_q.cnt) % n_act;
                for (int p = 0; p < P; p++) begin
                    if (act[p]) begin
                        if (c == k) upd_set[p] = 1'b1;
                        c = c + 1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_q <= '0;
        end else begin
            rb_q <= rb_d;
        end
    end

    assign busy    = rb_q.run | rb_q.pend;
    assign upd_en  = rb_q.run;
    assign upd_idx = rb_q.cnt;

    AST_WALK_ENDS_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_q.run && rb_q.cnt == LAST) |=> !rb_q.run) // R6
        else $error("rebuild did not stop after last entry");

    AST_WALK_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_q.run && rb_q.cnt != LAST) |=> (rb_q.run && rb_q.cnt == $past(rb_q.cnt) + 1'b1)) // R6
        else $error("rebuild skipped an entry");

    AST_SET_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> ((upd_set & ~rb_q.snap) == '0)) // R7
        else $error("inactive member chosen");
endmodule

// File: rtl/lagres_lookup.sv
module lagres_lookup #(
    parameter int P   = 7,
    parameter int E   = 16,
    parameter int AW  = 4,
    parameter int PIW = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lk_valid,
    input  logic                lk_ready,
    input  logic [PIW-1:0]      lk_dst,
    input  logic [AW-1:0]       lk_aggr,
    input  logic [PIW-1:0]      lk_src,
    input  logic [P-1:0][P-1:0] fwd_tbl,
    input  logic [E-1:0][P-1:0] sprd_tbl,
    input  logic [P-1:0][P-1:0] ingr_tbl,
    output logic                res_valid,
    output logic [P-1:0]        res_mask
);
    typedef struct packed {
        logic         valid;
        logic [P-1:0] mask;
    } res_t;

    res_t res_d, res_q;

    always_comb begin
        logic acc;
        res_d       = res_q;
        acc         = lk_valid && lk_ready;
        res_d.valid = acc;
        if (acc) begin
            if (int'(lk_dst) < P && int'(lk_src) < P) begin
                res_d.mask = fwd_tbl[lk_dst] & sprd_tbl[lk_aggr] & ingr_tbl[lk_src];
            end else begin
                res_d.mask = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid = res_q.valid;
    assign res_mask  = res_q.mask;

    AST_RES_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(lk_valid && lk_ready)) // R11
        else $error("result without accepted lookup");

    AST_NO_RES_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_ready) |=> !res_valid) // R9
        else $error("stalled lookup produced a result");

    AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready && (int'(lk_dst) >= P || int'(lk_src) >= P)) |=> (res_mask == '0)) // R2
        else $error("out of range index gave non-zero mask");
endmodule

// File: rtl/lagres_mask_resolver.sv
module lagres_mask_resolver #(
    parameter int NUM_PORTS  = 7,
    parameter int AGGR_CODES = 16,
    localparam int AW  = $clog2(AGGR_CODES),
    localparam int PIW = $clog2(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] link_up,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_sel,
    input  logic [AW-1:0]        cfg_idx,
    input  logic [NUM_PORTS-1:0] cfg_data,
    output logic                 cfg_ready,
    input  logic                 lk_valid,
    input  logic [PIW-1:0]       lk_dst,
    input  logic [AW-1:0]        lk_aggr,
    input  logic [PIW-1:0]       lk_src,
    output logic                 lk_ready,
    output logic                 res_valid,
    output logic [NUM_PORTS-1:0] res_mask
);
    localparam int P = NUM_PORTS;
    localparam int E = AGGR_CODES;

    logic                busy;
    logic                upd_en;
    logic [AW-1:0]       upd_idx;
    logic [P-1:0]        upd_clr;
    logic [P-1:0]        upd_set;
    logic [P-1:0][P-1:0] fwd_tbl;
    logic [E-1:0][P-1:0] sprd_tbl;
    logic [P-1:0][P-1:0] ingr_tbl;
    logic [P-1:0][P-1:0] grp_tbl;
    logic                grp_trig;

    lagres_tables #(.P(P), .E(E), .AW(AW), .PIW(PIW)) tables_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .busy(busy),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_clr(upd_clr), .upd_set(upd_set),
        .fwd_tbl(fwd_tbl), .sprd_tbl(sprd_tbl), .ingr_tbl(ingr_tbl), .grp_tbl(grp_tbl),
        .grp_trig(grp_trig)
    );

    lagres_rebuild #(.P(P), .E(E), .AW(AW)) rebuild_i (
        .clk(clk), .rst_n(rst_n),
        .trig(grp_trig), .link_in(link_up), .grp_tbl(grp_tbl),
        .busy(busy),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_clr(upd_clr), .upd_set(upd_set)
    );

    lagres_lookup #(.P(P), .E(E), .AW(AW), .PIW(PIW)) lookup_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_ready(lk_ready),
        .lk_dst(lk_dst), .lk_aggr(lk_aggr), .lk_src(lk_src),
        .fwd_tbl(fwd_tbl), .sprd_tbl(sprd_tbl), .ingr_tbl(ingr_tbl),
        .res_valid(res_valid), .res_mask(res_mask)
    );

    assign lk_ready  = !busy;
    assign cfg_ready = !busy;

    AST_READY_DROPS_ON_GROUP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        grp_trig |=> !lk_ready) // R9
        else $error("ready stayed high after group write");
endmodule

// File: tb/lagres_mask_resolver_tb.sv
module lagres_mask_resolver_tb_top;
    localparam int P = 7;
    localparam int E = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [P-1:0] link_up = '1;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_sel = '0;
    logic [3:0]   cfg_idx = '0;
    logic [P-1:0] cfg_data = '0;
    logic         cfg_ready;
    logic         lk_valid = 1'b0;
    logic [2:0]   lk_dst = '0;
    logic [3:0]   lk_aggr = '0;
    logic [2:0]   lk_src = '0;
    logic         lk_ready;
    logic         res_valid;
    logic [P-1:0] res_mask;

    int n_checks = 0;
    int n_fail = 0;

    int m_fwd [P];
    int m_sprd[E];
    int m_ingr[P];
    int m_grp [P];

    always #10 clk = ~clk;

    lagres_mask_resolver dut_i (
        .clk(clk), .rst_n(rst_n), .link_up(link_up),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .cfg_ready(cfg_ready),
        .lk_valid(lk_valid), .lk_dst(lk_dst), .lk_aggr(lk_aggr), .lk_src(lk_src),
        .lk_ready(lk_ready), .res_valid(res_valid), .res_mask(res_mask)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // expected spread table after a rebuild, from R6/R7
    task automatic model_rebuild();
        int allm;
        allm = 0;
        for (int g = 0; g < P; g++) allm |= m_grp[g];
        for (int e = 0; e < E; e++) begin
            int v;
            v = m_sprd[e] & ~allm;
            for (int g = 0; g < P; g++) begin
                int act;
                int n;
                int c;
                act = m_grp[g] & int'(link_up);
                n = $countones(act[P-1:0]);
                c = 0;
                if (n != 0) begin
                    for (int p = 0; p < P; p++) begin
                        if (act[p]) begin
                            if (c == e % n) v |= (1 << p);
                            c++;
                        end
                    end
                end
            end
            m_sprd[e] = v;
        end
    endtask

    task automatic cfg_write(input int sel, input int idx, input int data);
        cfg_we   = 1'b1;
        cfg_sel  = 2'(sel);
        cfg_idx  = 4'(idx);
        cfg_data = P'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (3) @(negedge clk);
        while (!lk_ready) @(negedge clk);
    endtask

    task automatic sweep(input string tag);
        for (int d = 0; d < 8; d++) begin
            for (int a = 0; a < E; a++) begin
                for (int s = 0; s < 8; s++) begin
                    int exp;
                    lk_valid = 1'b1;
                    lk_dst   = 3'(d);
                    lk_aggr  = 4'(a);
                    lk_src   = 3'(s);
                    @(negedge clk);
                    exp = (d < P && s < P) ? (m_fwd[d] & m_sprd[a] & m_ingr[s]) : 0;
                    check(res_valid === 1'b1, "R11", int'(res_valid), 1);
                    check(int'(res_mask) == exp, (d >= P || s >= P) ? "R2" : tag, int'(res_mask), exp);
                end
            end
        end
        lk_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < P; i++) begin
            m_fwd[i]  = 1 << i;
            m_ingr[i] = 'h7F & ~(1 << i);
            m_grp[i]  = 0;
        end
        for (int e = 0; e < E; e++) m_sprd[e] = 'h7F;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        wait_idle();
        check(lk_ready === 1'b1, "R3", int'(lk_ready), 1);
        check(res_valid === 1'b0, "R3", int'(res_valid), 0);
        sweep("R3");

        // R4: group {1,2} with logical index 1, all links up
        cfg_write(3, 1, 'b0000110);
        m_grp[1] = 'b0000110;
        m_fwd[1] = 'b0000110;
        m_fwd[2] = 'b0000110;
        // R9: busy right after a group write
        check(lk_ready === 1'b0, "R9", int'(lk_ready), 0);
        // R10: direct write during rebuild is dropped
        check(cfg_ready === 1'b0, "R10", int'(cfg_ready), 0);
        cfg_write(0, 0, 0);
        lk_valid = 1'b1;
        @(negedge clk);
        check(res_valid === 1'b0, "R9", int'(res_valid), 0);
        lk_valid = 1'b0;
        wait_idle();
        model_rebuild();
        sweep("R4");

        // R6: group {3,4,5}, port 4 down
        cfg_write(3, 3, 'b0111000);
        m_grp[3] = 'b0111000;
        m_fwd[3] = 'b0111000;
        m_fwd[4] = 'b0111000;
        m_fwd[5] = 'b0111000;
        wait_idle();
        link_up = 7'b1101111;
        wait_idle();
        model_rebuild();
        sweep("R6");

        // R7: no active members in group {1,2}
        link_up = 7'b1101001;
        wait_idle();
        model_rebuild();
        sweep("R7");

        // R5: rejected group writes: index not lowest member, and index out of range
        cfg_write(3, 5, 'b0110000);
        cfg_write(3, 9, 'b0000001);
        @(negedge clk);
        check(lk_ready === 1'b1, "R5", int'(lk_ready), 1);
        sweep("R5");

        // R8: dissolve group 3, all links back
        cfg_write(3, 3, 0);
        for (int p = 3; p <= 5; p++) begin
            m_fwd[p] = 1 << p;
            for (int e = 0; e < E; e++) m_sprd[e] |= (1 << p);
        end
        m_grp[3] = 0;
        wait_idle();
        model_rebuild();
        link_up = '1;
        wait_idle();
        model_rebuild();
        sweep("R8");

        // R1: direct writes to each table
        cfg_write(0, 6, 'b1010101);
        m_fwd[6] = 'b1010101;
        cfg_write(1, 15, 'b1110001);
        m_sprd[15] = 'b1110001;
        cfg_write(2, 0, 'b1000111);
        m_ingr[0] = 'b1000111;
        cfg_write(0, 12, 'b1111111);
        @(negedge clk);
        sweep("R1");

        finish_run();
    end
endmodule